// File: doc/BRIEF.md
# Sign-Magnitude Programmable FIR Filter

This block is a synchronous finite impulse response filter whose samples, coefficients and results are all kept in sign-magnitude fixed point. A 2-bit command input selects what the 9-bit data input carries. One command loads the eight tap weights one after another. Another streams a packet of 32 samples through the filter. A third leaves the filter idle. Each data word is held on the input for a fixed number of clocks. The filter samples the word once, on the first clock of its hold window. It then counts out the rest of the window before it takes the next word.

For each accepted sample, the filter shifts it into an eight-deep delay line. It then walks the taps with a single unsigned magnitude multiplier, one tap per clock. The sign of each product is the XOR of the operand signs. The signed products are summed and converted back to sign-magnitude. The delay line is zeroed when a packet starts. Because the window is still filling, the first seven samples of a packet produce no output. Each sample after that yields one result, marked by a one-clock valid pulse.

Top module: `smfir_core`

## Requirements
- R1: While reset is held and in the first clock after it, `y_out` is 0 and `y_valid` is 0.
- R2: With the filter idle, command 2'b01 loads eight coefficients in tap order h0 to h7. The first word is taken in the clock where the command is first seen, and each later word COEF_HOLD clocks after the previous one. Coefficient bit 8 is the sign, and bits 7:0 are the magnitude with 7 fraction bits (128 = 1.0).
- R3: A coefficient whose magnitude exceeds 128 is stored with magnitude 128, keeping its sign.
- R4: With the filter idle, command 2'b10 runs a packet of 32 samples. The first sample is taken in the clock where the command is first seen, and each later one SAMPLE_HOLD clocks after the previous one. Values on `x_in` in any other clock have no effect on the results.
- R5: The result for sample n is the sum over k = 0..7 of h[k]*x[n-k]. Each product is the product of the two magnitudes, and its sign is the XOR of the two sign bits.
- R6: Samples and results use bit 8 as the sign, bits 7:6 as the integer part and bits 5:0 as the fraction. The result magnitude is the magnitude of the 13-fraction-bit sum with its 7 low bits dropped (truncation toward zero).
- R7: A result magnitude above 255 is output as 255, keeping the sign of the sum.
- R8: A result whose magnitude is 0 has sign bit 0.
- R9: `y_valid` is high for exactly one clock for each packet sample with index 7 or higher, which gives 25 pulses per packet. The pulse comes 9 clocks after the clock in which that sample was taken, and `y_out` carries the result in the same clock. Samples 0 to 6 produce no pulse.
- R10: Changes on `cmd` are ignored while a load or a packet is in progress. After one completes, no new command starts until `cmd` has been 2'b11. Command 2'b00 or 2'b11 seen while idle starts nothing and leaves the coefficients unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 01 load coefficients, 10 run packet, 11 idle, 00 no action |
| x_in | input | 9 | Coefficient or sample word, sign-magnitude |
| y_out | output | 9 | Filter result, sign-magnitude |
| y_valid | output | 1 | One-clock strobe marking a new result on `y_out` |

## Verification
The assertions in the multiply-accumulate stage assume that a new sample never arrives while the eight-clock tap walk of the previous one is still running. That holds only because the sample hold time is at least one clock longer than the tap count, and an elaboration check enforces this bound. They also assume that coefficient and sample words arrive only through the command sequences. The stimulus therefore starts every command from the idle state, after at least two clocks of 2'b11. It keeps the run command asserted until the packet's last hold window has closed. It puts unrelated values on `x_in` between sampling clocks, so a result that is right can only come from sampling in the right clock.

// File: rtl/smfir_pkg.sv
package smfir_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_COEF = 2'b01,
      CMD_RUN  = 2'b10,
      CMD_IDLE = 2'b11
   } smfir_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RUN,
      ST_DONE
   } smfir_state_e;

endpackage

// File: rtl/smfir_ctrl.sv
module smfir_ctrl
   import smfir_pkg::*;
#(
   parameter int TAPS        = 8,
   parameter int PKT_LEN     = 32,
   parameter int SAMPLE_HOLD = 9,
   parameter int COEF_HOLD   = 3,
   localparam int IDXW = (TAPS > 1) ? $clog2(TAPS) : 1,
   localparam int CMAX = (PKT_LEN > TAPS) ? PKT_LEN : TAPS,
   localparam int WCW  = $clog2(CMAX + 1),
   localparam int HMAX = (SAMPLE_HOLD > COEF_HOLD) ? SAMPLE_HOLD : COEF_HOLD,
   localparam int HCW  = $clog2(HMAX + 1)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cmd_i,
   output logic            coef_we_o,
   output logic [IDXW-1:0] coef_idx_o,
   output logic            smp_shift_o,
   output logic            smp_clear_o,
   output logic            smp_emit_o
);

   smfir_state_e   st_q, st_d;
   logic [HCW-1:0] hold_q, hold_d;
   logic [WCW-1:0] cnt_q, cnt_d;

   // next-state and strobe logic
   always_comb begin
      st_d        = st_q;
      hold_d      = hold_q;
      cnt_d       = cnt_q;
      coef_we_o   = 1'b0;
      smp_shift_o = 1'b0;
      smp_clear_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cmd_i == CMD_COEF) begin
               st_d      = ST_LOAD;
               coef_we_o = 1'b1;
               hold_d    = HCW'(COEF_HOLD - 1);
               cnt_d     = WCW'(1);
            end else if (cmd_i == CMD_RUN) begin
               st_d        = ST_RUN;
               smp_shift_o = 1'b1;
               smp_clear_o = 1'b1;
               hold_d      = HCW'(SAMPLE_HOLD - 1);
               cnt_d       = WCW'(1);
            end
         end
         ST_LOAD: begin
            if (hold_q != '0) begin
               hold_d = hold_q - HCW'(1);
            end else if (cnt_q == WCW'(TAPS)) begin
               st_d = ST_DONE;
            end else begin
               coef_we_o = 1'b1;
               hold_d    = HCW'(COEF_HOLD - 1);
               cnt_d     = cnt_q + WCW'(1);
            end
         end
         ST_RUN: begin
            if (hold_q != '0) begin
               hold_d = hold_q - HCW'(1);
            end else if (cnt_q == WCW'(PKT_LEN)) begin
               st_d = ST_DONE;
            end else begin
               smp_shift_o = 1'b1;
               hold_d      = HCW'(SAMPLE_HOLD - 1);
               cnt_d       = cnt_q + WCW'(1);
            end
         end
         ST_DONE: begin
            if (cmd_i == CMD_IDLE) st_d = ST_IDLE;
         end
      endcase
   end

   // state memory
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
         cnt_q  <= '0;
      end else begin
         st_q   <= st_d;
         hold_q <= hold_d;
         cnt_q  <= cnt_d;
      end
   end

   // output decode
   assign coef_idx_o = (st_q == ST_LOAD) ? cnt_q[IDXW-1:0] : '0;
   assign smp_emit_o = (st_q == ST_IDLE) ? (TAPS == 1) : (cnt_q >= WCW'(TAPS - 1));

   p_shift_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((SAMPLE_HOLD > 1) && smp_shift_o) |=> !smp_shift_o)
      else $error("sample accepted twice inside one hold window");

   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= WCW'(CMAX))
      else $error("word counter past command length");

   p_done_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE && cmd_i != CMD_IDLE) |=> (st_q == ST_DONE))
      else $error("left completion state without idle command");

endmodule

// File: rtl/smfir_taps.sv
module smfir_taps #(
   parameter int TAPS  = 8,
   parameter int DW    = 9,
   parameter int CW    = 9,
   parameter int CFRAC = 7,
   localparam int IDXW = (TAPS > 1) ? $clog2(TAPS) : 1,
   localparam int XMW  = DW - 1,
   localparam int HMW  = CW - 1,
   localparam int ONE  = 1 << CFRAC
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   din_i,
   input  logic            coef_we_i,
   input  logic [IDXW-1:0] coef_idx_i,
   input  logic            shift_i,
   input  logic            clear_i,
   input  logic [IDXW-1:0] tap_i,
   output logic            x_sgn_o,
   output logic [XMW-1:0]  x_mag_o,
   output logic            h_sgn_o,
   output logic [HMW-1:0]  h_mag_o
);

   logic           coef_sgn [TAPS];
   logic [HMW-1:0] coef_mag [TAPS];
   logic           dl_sgn   [TAPS];
   logic [XMW-1:0] dl_mag   [TAPS];

   // incoming coefficient magnitude limited to unity
   logic [HMW-1:0] cmag_in;
   assign cmag_in = (din_i[HMW-1:0] > HMW'(ONE)) ? HMW'(ONE) : din_i[HMW-1:0];

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic           hs_q;
      logic [HMW-1:0] hm_q;
      logic           xs_q;
      logic [XMW-1:0] xm_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hs_q <= 1'b0;
            hm_q <= '0;
         end else if (coef_we_i && coef_idx_i == IDXW'(k)) begin
            hs_q <= din_i[DW-1];
            hm_q <= cmag_in;
         end
      end

      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               xs_q <= 1'b0;
               xm_q <= '0;
            end else if (shift_i) begin
               xs_q <= din_i[DW-1];
               xm_q <= din_i[XMW-1:0];
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               xs_q <= 1'b0;
               xm_q <= '0;
            end else if (shift_i) begin
               xs_q <= clear_i ? 1'b0 : dl_sgn[k-1];
               xm_q <= clear_i ? '0   : dl_mag[k-1];
            end
         end
      end

      assign coef_sgn[k] = hs_q;
      assign coef_mag[k] = hm_q;
      assign dl_sgn[k]   = xs_q;
      assign dl_mag[k]   = xm_q;
   end

   // tap selection for the serial multiplier
   assign x_sgn_o = dl_sgn[tap_i];
   assign x_mag_o = dl_mag[tap_i];
   assign h_sgn_o = coef_sgn[tap_i];
   assign h_mag_o = coef_mag[tap_i];

   p_coef_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we_i |=> (coef_mag[$past(coef_idx_i)] <= HMW'(ONE)))
      else $error("stored coefficient magnitude above unity");

endmodule

// File: rtl/smfir_mac.sv
module smfir_mac #(
   parameter int TAPS       = 8,
   parameter int DW         = 9,
   parameter int CW         = 9,
   parameter int CFRAC      = 7,
   parameter bit MULT_ARRAY = 1'b1,
   localparam int IDXW = (TAPS > 1) ? $clog2(TAPS) : 1,
   localparam int XMW  = DW - 1,
   localparam int HMW  = CW - 1,
   localparam int PW   = XMW + HMW,
   localparam int ACCW = PW + $clog2(TAPS) + 2,
   localparam int OMAX = (1 << XMW) - 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            emit_i,
   input  logic            x_sgn_i,
   input  logic [XMW-1:0]  x_mag_i,
   input  logic            h_sgn_i,
   input  logic [HMW-1:0]  h_mag_i,
   output logic [IDXW-1:0] tap_o,
   output logic [DW-1:0]   y_o,
   output logic            y_valid_o
);

   logic [PW-1:0] prod;

   if (MULT_ARRAY) begin : g_array_mult
      logic [PW-1:0] pp [HMW];
      for (genvar b = 0; b < HMW; b++) begin : g_pp
         assign pp[b] = h_mag_i[b] ? (PW'(x_mag_i) << b) : '0;
      end
      always_comb begin
         prod = '0;
         for (int b = 0; b < HMW; b++) prod = prod + pp[b];
      end
   end else begin : g_op_mult
      assign prod = PW'(x_mag_i) * PW'(h_mag_i);
   end

   logic                   psgn;
   logic signed [ACCW-1:0] term, acc_q, acc_sum;
   assign psgn    = x_sgn_i ^ h_sgn_i;
   assign term    = psgn ? -$signed(ACCW'(prod)) : $signed(ACCW'(prod));
   assign acc_sum = acc_q + term;

   // back to sign-magnitude: truncate toward zero, then saturate
   logic [ACCW-1:0] abs_sum, shifted;
   logic [XMW-1:0]  ymag;
   logic            ysgn;
   assign abs_sum = acc_sum[ACCW-1] ? ACCW'(-acc_sum) : ACCW'(acc_sum);
   assign shifted = abs_sum >> CFRAC;
   assign ymag    = (shifted > ACCW'(OMAX)) ? XMW'(OMAX) : shifted[XMW-1:0];
   assign ysgn    = acc_sum[ACCW-1] && (ymag != '0);

   logic            busy_q, emit_q, last;
   logic [IDXW-1:0] tap_q;
   assign last  = (tap_q == IDXW'(TAPS - 1));
   assign tap_o = tap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         emit_q    <= 1'b0;
         tap_q     <= '0;
         acc_q     <= '0;
         y_o       <= '0;
         y_valid_o <= 1'b0;
      end else begin
         y_valid_o <= !start_i && busy_q && last && emit_q;
         if (start_i) begin
            busy_q <= 1'b1;
            emit_q <= emit_i;
            tap_q  <= '0;
            acc_q  <= '0;
         end else if (busy_q) begin
            acc_q <= acc_sum;
            if (last) begin
               busy_q <= 1'b0;
               if (emit_q) y_o <= {ysgn, ymag};
            end else begin
               tap_q <= tap_q + IDXW'(1);
            end
         end
      end
   end

   p_start_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q)
      else $error("sample arrived during tap walk");

   p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid_o |=> !y_valid_o)
      else $error("valid held longer than one clock");

   p_valid_after_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid_o |-> $past(busy_q))
      else $error("valid without a preceding tap walk");

   p_no_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid_o |-> !(y_o[DW-1] && y_o[XMW-1:0] == '0))
      else $error("negative zero on output");

endmodule

// File: rtl/smfir_core.sv
module smfir_core #(
   parameter int TAPS        = 8,
   parameter int PKT_LEN     = 32,
   parameter int DW          = 9,
   parameter int CW          = 9,
   parameter int CFRAC       = 7,
   parameter int SAMPLE_HOLD = 9,
   parameter int COEF_HOLD   = 3,
   parameter bit MULT_ARRAY  = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cmd,
   input  logic [DW-1:0] x_in,
   output logic [DW-1:0] y_out,
   output logic          y_valid
);

   localparam int IDXW = (TAPS > 1) ? $clog2(TAPS) : 1;
   localparam int XMW  = DW - 1;
   localparam int HMW  = CW - 1;

   initial begin
      assert (SAMPLE_HOLD >= TAPS + 1) else $error("sample hold shorter than tap walk");
      assert (COEF_HOLD >= 1)          else $error("coefficient hold must be positive");
      assert (CW <= DW)                else $error("coefficient wider than data input");
      assert (CFRAC < HMW)             else $error("unity does not fit coefficient magnitude");
      assert (PKT_LEN >= TAPS)         else $error("packet shorter than window");
   end

   logic            coef_we, smp_shift, smp_clear, smp_emit;
   logic [IDXW-1:0] coef_idx, tap;
   logic            x_sgn, h_sgn;
   logic [XMW-1:0]  x_mag;
   logic [HMW-1:0]  h_mag;

   smfir_ctrl #(
      .TAPS(TAPS), .PKT_LEN(PKT_LEN),
      .SAMPLE_HOLD(SAMPLE_HOLD), .COEF_HOLD(COEF_HOLD)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
      .coef_we_o(coef_we), .coef_idx_o(coef_idx),
      .smp_shift_o(smp_shift), .smp_clear_o(smp_clear), .smp_emit_o(smp_emit)
   );

   smfir_taps #(
      .TAPS(TAPS), .DW(DW), .CW(CW), .CFRAC(CFRAC)
   ) u_taps (
      .clk(clk), .rst_n(rst_n), .din_i(x_in),
      .coef_we_i(coef_we), .coef_idx_i(coef_idx),
      .shift_i(smp_shift), .clear_i(smp_clear), .tap_i(tap),
      .x_sgn_o(x_sgn), .x_mag_o(x_mag), .h_sgn_o(h_sgn), .h_mag_o(h_mag)
   );

   smfir_mac #(
      .TAPS(TAPS), .DW(DW), .CW(CW), .CFRAC(CFRAC), .MULT_ARRAY(MULT_ARRAY)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .start_i(smp_shift), .emit_i(smp_emit),
      .x_sgn_i(x_sgn), .x_mag_i(x_mag), .h_sgn_i(h_sgn), .h_mag_i(h_mag),
      .tap_o(tap), .y_o(y_out), .y_valid_o(y_valid)
   );

endmodule

// File: tb/smfir_core_test.sv
module smfir_core_test;

   localparam int CLK_PERIOD = 10;
   localparam int L  = 9;
   localparam int K  = 3;
   localparam int NT = 8;
   localparam int NP = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b11;
   logic [8:0] x = '0;
   wire  [8:0] y;
   wire        yv;

   int errs = 0;
   int checks = 0;
   int hval [NT];
   int samp [NP];
   logic [8:0] cw [NT];
   logic [8:0] sw [NP];
   int seed = 12345;

   always #(CLK_PERIOD/2) clk = ~clk;

   smfir_core #(.SAMPLE_HOLD(L), .COEF_HOLD(K)) uut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .x_in(x), .y_out(y), .y_valid(yv)
   );

   function automatic int sm2int(logic [8:0] v);
      return v[8] ? -int'(v[7:0]) : int'(v[7:0]);
   endfunction

   function automatic logic [8:0] expect_y(int n);
      int s = 0;
      int m;
      for (int k = 0; k < NT; k++) s += hval[k] * samp[n-k];
      m = ((s < 0) ? -s : s) >> 7;
      if (m > 255) m = 255;
      return {(s < 0) && (m != 0), 8'(m)};
   endfunction

   function automatic logic [8:0] rnd9();
      seed = seed * 1103515245 + 12345;
      return 9'((seed >>> 11) & 511);
   endfunction

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (2) begin
         @(negedge clk);
         cmd = 2'b11;
         x   = '0;
      end
   endtask

   // coefficient load; disturb scrambles cmd while the load is in progress (R10)
   task automatic load_coefs(input bit disturb);
      for (int c = 0; c < NT*K + 2; c++) begin
         @(negedge clk);
         chk("R2", int'(yv), 0, "no valid during load");
         if (disturb && c > 0 && c < NT*K)
            cmd = (c % 3 == 0) ? 2'b10 : ((c % 3 == 1) ? 2'b11 : 2'b00);
         else
            cmd = 2'b01;
         x = (c % K == 0 && c / K < NT) ? cw[c/K] : 9'((c * 71 + 29) % 512);
      end
      for (int k = 0; k < NT; k++) begin
         int m = int'(cw[k][7:0]);
         if (m > 128) m = 128;
         hval[k] = cw[k][8] ? -m : m;
      end
      settle();
   endtask

   // packet run with junk between sampling clocks (R4) and per-clock valid check (R9)
   task automatic run_packet(input bit disturb, input string tag);
      int nvalid = 0;
      for (int i = 0; i < NP; i++) samp[i] = sm2int(sw[i]);
      for (int d = 0; d < NP*L + 3; d++) begin
         bit exp_v;
         @(negedge clk);
         exp_v = (d >= 9) && ((d - 9) % L == 0) && ((d - 9) / L >= NT - 1) && ((d - 9) / L < NP);
         chk("R9", int'(yv), int'(exp_v), "y_valid timing");
         if (exp_v) begin
            nvalid++;
            chk(tag, int'(y), int'(expect_y((d - 9) / L)), "y_out");
         end
         if (disturb && d > 0 && d < NP*L)
            cmd = (d % 3 == 0) ? 2'b01 : ((d % 3 == 1) ? 2'b11 : 2'b00);
         else
            cmd = 2'b10;
         x = (d % L == 0 && d / L < NP) ? sw[d/L] : 9'((d * 53 + 17) % 512);
      end
      chk("R9", nvalid, NP - NT + 1, "valid count");
      settle();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", int'(y), 0, "y_out in reset");
      chk("R1", int'(yv), 0, "y_valid in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(y), 0, "y_out after reset");
      chk("R1", int'(yv), 0, "y_valid after reset");
      settle();

      // R3: mixed signs, two magnitudes above unity
      cw = '{9'h080, 9'h140, 9'h020, 9'h1FF, 9'h0C5, 9'h010, 9'h100, 9'h003};
      load_coefs(1'b0);
      for (int i = 0; i < NP; i++) sw[i] = {i[0], 8'(i * 8 + 3)};
      run_packet(1'b0, "R3");

      // R10: cmd scrambled during the packet
      for (int i = 0; i < NP; i++) sw[i] = {i[1], 8'(255 - i * 5)};
      run_packet(1'b1, "R10");

      // R10: 00 and 11 while idle start nothing
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         chk("R10", int'(yv), 0, "no valid while idle");
         cmd = (c < 10) ? 2'b00 : 2'b11;
         x   = 9'h0FF;
      end
      for (int i = 0; i < NP; i++) sw[i] = {1'b0, 8'(i * 3)};
      run_packet(1'b0, "R10");

      // R2: tap order through an impulse at sample 7, load with scrambled cmd
      cw = '{9'h001, 9'h002, 9'h004, 9'h008, 9'h010, 9'h020, 9'h040, 9'h080};
      load_coefs(1'b1);
      for (int i = 0; i < NP; i++) sw[i] = (i == 7 || i == 20) ? 9'h0C0 : 9'h000;
      run_packet(1'b0, "R2");

      // R7: saturation with both signs
      cw = '{default: 9'h080};
      load_coefs(1'b0);
      for (int i = 0; i < NP; i++) sw[i] = (i < 16) ? 9'h0FF : 9'h1FF;
      run_packet(1'b0, "R7");

      // R8: small negative sum truncates to positive zero
      cw = '{default: 9'h001};
      load_coefs(1'b0);
      for (int i = 0; i < NP; i++) sw[i] = (i % 2 == 0) ? 9'h101 : 9'h102;
      run_packet(1'b0, "R8");

      // sweep of pseudo-random coefficient and sample sets (R4, R5, R6)
      for (int p = 0; p < 6; p++) begin
         for (int k = 0; k < NT; k++) cw[k] = rnd9();
         load_coefs(1'b0);
         for (int i = 0; i < NP; i++) sw[i] = rnd9();
         run_packet(1'b0, (p % 3 == 0) ? "R4" : ((p % 3 == 1) ? "R5" : "R6"));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule